// File: doc/BRIEF.md
# RGB Pixel-Stream Frame Writer

This block takes a moving-picture pixel stream from an external video source and turns it into write cycles on a frame memory. The stream is timed by a dot clock, an active-low vertical sync and an active-low horizontal sync. An 18-bit pixel bus is qualified by a data-enable input. Every accepted pixel becomes one write of 18 bits. The write address is derived from a line count and a pixel count, and the two syncs reposition both counts.

Writes happen only for enabled pixels and land where the syncs place them. The frame can therefore be refreshed while the panel is being scanned from the same memory, without visible tearing. The memory holds 240 pixels by 320 lines. Pixels or lines outside that window are discarded, so stray timing from the source cannot corrupt other rows.

Top module: `rgb_frame_writer`

## Requirements
- R1: While `rst` is high on a clock edge, `wr_en` is 0 in the following cycle. The first accepted pixel after reset is written to address 0.
- R2: A pixel is accepted only on a clock edge where `de`, `vsync_n` and `hsync_n` are all high. With `de` low or either sync low, `wr_en` stays 0 in the next cycle.
- R3: Accepted pixels on one line that fall inside the window are written to consecutive ascending addresses, starting at the line's first address.
- R4: The write address equals line × 240 + pixel, where both counts start at 0. It is always below 76800.
- R5: While `vsync_n` is low, the line and pixel counts are held at 0. The next accepted pixel is written to address 0.
- R6: A high-to-low transition of `hsync_n` resets the pixel count to 0. It advances the line count by one only if at least one pixel was accepted since the previous horizontal or vertical sync.
- R7: Holding `hsync_n` low for several cycles advances the line count at most once.
- R8: Accepted pixels beyond the 240th on a line produce no write.
- R9: Accepted pixels on lines beyond the 320th (line count 320 or more) produce no write.
- R10: On a write, `wr_data` equals the pixel value that was sampled with it. `wr_en`, `wr_addr` and `wr_data` all appear one clock after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vsync_n | input | 1 | Vertical sync, active low |
| hsync_n | input | 1 | Horizontal sync, active low |
| de | input | 1 | Pixel data enable, active high |
| pix | input | 18 | Pixel value |
| wr_en | output | 1 | Frame-memory write strobe, one cycle per pixel |
| wr_addr | output | 17 | Frame-memory word address |
| wr_data | output | 18 | Frame-memory write data |

## Verification
Every result is registered once. The write for a pixel driven before edge N is visible after edge N, and the bench reads it at the falling edge that follows. The effect of a sync reaches the counters at the edge that samples it, so it first shows in the address of the next accepted pixel. Each scenario task drives inputs on falling edges and steps exactly one rising edge per pixel or sync cycle. It then compares `wr_en`, `wr_addr` and `wr_data` at the next falling edge against a model of line, pixel and seen flag kept in the bench.

// File: rtl/rgb_frame_writer.sv
module rgb_frame_writer #(
  parameter int H_PIX   = 240,
  parameter int V_LINES = 320,
  parameter int PIX_W   = 18,
  localparam int ADDR_W = $clog2(H_PIX * V_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vsync_n,
  input  logic              hsync_n,
  input  logic              de,
  input  logic [PIX_W-1:0]  pix,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PIX_W-1:0]  wr_data
);

  localparam int PC_W = $clog2(H_PIX + 1);
  localparam int LC_W = $clog2(V_LINES + 1);

  logic [PC_W-1:0]   pix_cnt;
  logic [LC_W-1:0]   line_cnt;
  logic [ADDR_W:0]   line_base;
  logic              seen;
  logic              hs_q;

  wire take   = de & vsync_n & hsync_n;
  wire hs_fall = hs_q & ~hsync_n;
  wire pix_ok  = pix_cnt < PC_W'(H_PIX);
  wire line_ok = line_cnt < LC_W'(V_LINES);
  wire in_win  = pix_ok & line_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_cnt   <= '0;
      line_cnt  <= '0;
      line_base <= '0;
      seen      <= 1'b0;
      hs_q      <= 1'b1;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      hs_q  <= hsync_n;
      wr_en <= take & in_win;
      if (take && in_win) begin
        wr_addr <= ADDR_W'(line_base + (ADDR_W+1)'(pix_cnt));
        wr_data <= pix;
      end
      if (!vsync_n) begin
        pix_cnt   <= '0;
        line_cnt  <= '0;
        line_base <= '0;
        seen      <= 1'b0;
      end else if (hs_fall) begin
        pix_cnt <= '0;
        seen    <= 1'b0;
        if (seen && line_ok) begin
          line_cnt  <= line_cnt + 1'b1;
          line_base <= line_base + (ADDR_W+1)'(H_PIX);
        end
      end else if (take) begin
        seen <= 1'b1;
        if (pix_ok) pix_cnt <= pix_cnt + 1'b1;
      end
    end
  end

  AST_RST_QUIET:  assert property (@(posedge clk) rst |=> !wr_en); // R1
  AST_NO_DE_NO_WR: assert property (@(posedge clk) disable iff (rst) !de |=> !wr_en); // R2
  AST_HS_NO_WR:   assert property (@(posedge clk) disable iff (rst) !hsync_n |=> !wr_en); // R2
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst) wr_en |-> (int'(wr_addr) < H_PIX * V_LINES)); // R4
  AST_VS_HOLDS:   assert property (@(posedge clk) disable iff (rst) !vsync_n |=> (!wr_en && line_cnt == '0 && pix_cnt == '0)); // R5
  AST_LINE_STEP:  assert property (@(posedge clk) disable iff (rst) vsync_n |=> (line_cnt == $past(line_cnt) || line_cnt == $past(line_cnt) + 1'b1)); // R6
  AST_HS_ONCE:    assert property (@(posedge clk) disable iff (rst) (!hsync_n && !hs_q && vsync_n) |=> $stable(line_cnt)); // R7
  AST_LINE_SAT:   assert property (@(posedge clk) disable iff (rst) line_cnt <= LC_W'(V_LINES)); // R9

endmodule

// File: tb/sim_rgb_frame_writer.sv
module sim_rgb_frame_writer;
  localparam int H = 240;
  localparam int V = 320;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vsync_n = 1'b1;
  logic        hsync_n = 1'b1;
  logic        de = 1'b0;
  logic [17:0] pix = '0;
  logic        wr_en;
  logic [16:0] wr_addr;
  logic [17:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;
  int mline = 0, mpix = 0;
  bit mseen = 0;

  always #5 clk = ~clk;

  rgb_frame_writer u0 (
    .clk(clk), .rst(rst), .vsync_n(vsync_n), .hsync_n(hsync_n),
    .de(de), .pix(pix), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [17:0] d, input string req);
    bit ew;
    int ea;
    de  = 1'b1;
    pix = d;
    ew  = vsync_n && hsync_n && mpix < H && mline < V;
    ea  = mline * H + mpix;
    if (vsync_n && hsync_n) begin
      mseen = 1;
      if (mpix < H) mpix++;
    end
    step();
    de = 1'b0;
    chk(req, "wr_en", int'(wr_en), int'(ew));
    if (ew) begin
      chk(req, "wr_addr", int'(wr_addr), ea);
      chk(req, "wr_data", int'(wr_data), int'(d));
    end
  endtask

  task automatic hs(input int hold, input string req);
    hsync_n = 1'b0;
    mpix = 0;
    if (mseen && mline < V) mline++;
    mseen = 0;
    for (int i = 0; i < hold; i++) begin
      step();
      chk(req, "wr_en in hsync", int'(wr_en), 0);
    end
    hsync_n = 1'b1;
  endtask

  task automatic vs(input string req);
    vsync_n = 1'b0;
    mline = 0; mpix = 0; mseen = 0;
    de = 1'b1; pix = 18'h2AAAA;
    step();
    chk(req, "wr_en in vsync", int'(wr_en), 0);
    step();
    de = 1'b0;
    chk(req, "wr_en in vsync", int'(wr_en), 0);
    vsync_n = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    mline = 0; mpix = 0; mseen = 0;
    chk("R1", "wr_en after reset", int'(wr_en), 0);
    push(18'h00011, "R1");
  endtask

  task automatic t_line();
    for (int i = 0; i < 5; i++) push(18'(18'h30000 + i), "R3");
    push(18'h3FFFF, "R10");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 4; i++) begin
      pix = 18'(i * 77);
      step();
      chk("R2", "wr_en with de low", int'(wr_en), 0);
    end
  endtask

  task automatic t_hsync();
    hs(1, "R6");
    push(18'h00100, "R4");
    push(18'h00101, "R4");
    hs(2, "R6");
    hs(2, "R6");
    push(18'h00200, "R6");
    hs(5, "R7");
    push(18'h00300, "R7");
    hsync_n = 1'b0;
    mpix = 0;
    if (mseen && mline < V) mline++;
    mseen = 0;
    push(18'h00400, "R2");
    push(18'h00401, "R2");
    hsync_n = 1'b1;
    push(18'h00402, "R6");
  endtask

  task automatic t_pix_over();
    hs(1, "R6");
    for (int i = 0; i < H + 5; i++) push(18'(i), "R8");
  endtask

  task automatic t_vsync();
    vs("R5");
    push(18'h12345, "R5");
    push(18'h12346, "R5");
  endtask

  task automatic t_last_lines();
    vs("R5");
    for (int l = 0; l < V + 2; l++) begin
      push(18'(l), "R9");
      push(18'(l + 1), "R9");
      hs(1, "R9");
    end
    push(18'h3C3C3, "R9");
  endtask

  task automatic t_reset_mid();
    push(18'h01010, "R3");
    t_reset();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_line();
    t_idle();
    t_hsync();
    t_pix_over();
    t_vsync();
    t_last_lines();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule